// File: doc/BRIEF.md
# Sequential 16x16 Multiplier Built on One 8x8 Unit

This block forms the 32-bit product of two 16-bit operands over several clock cycles. It uses a single unsigned 8x8 multiplier. The block works through four byte pairings of the operands in a fixed order. Each 16-bit partial product is merged into a 32-bit working accumulator at the byte position it belongs to:

- low×low is written directly into the lower half;
- high×high is written directly into the upper half;
- the two cross products are each added at an offset of one byte.

A mode input selects unsigned or two's-complement operation. In signed mode the accumulator first holds the unsigned product. That value is then corrected by up to two subtractions from its upper 16 bits: one for each operand whose sign bit is set.

A caller presents both operands and the mode with a one-cycle start request while the block is idle. The block raises busy for the length of the computation. It then loads the result register and pulses done for one cycle. The result register keeps its value until the next operation completes. A request made while busy has no effect.

Top module: `mul16_seq`

## Requirements
- R1: After reset, busy_o and done_o are 0 and result_o is 0.
- R2: When start_i is 1 while busy_o is 0, the block latches op_a_i, op_b_i and signed_i at that clock edge, and busy_o is 1 in the following cycle.
- R3: With signed_i = 0 at acceptance, result_o equals the unsigned product op_a_i × op_b_i as a 32-bit value.
- R4: An unsigned operation keeps busy_o high for exactly 4 cycles.
- R5: With signed_i = 1 at acceptance, result_o equals the two's-complement product of the two operands modulo 2^32. Bit 15 of each operand is its sign.
- R6: A signed operation keeps busy_o high for 4 cycles, plus one cycle for each operand whose bit 15 is 1. Its length is therefore 4, 5 or 6 cycles.
- R7: done_o is a one-cycle pulse. It is high exactly in the first cycle in which busy_o is low after an operation, and result_o holds the new product in that cycle.
- R8: A start_i while busy_o is 1 is ignored. Operand or mode changes during that time do not alter the result or the length of the operation, and no extra operation follows.
- R9: result_o keeps its value at every cycle except the one in which done_o is high, including throughout a following operation.
- R10: A start_i in the cycle where done_o is high is accepted as a new operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Request to begin an operation; taken only while idle |
| signed_i | input | 1 | 1 selects two's-complement mode, 0 selects unsigned |
| op_a_i | input | 16 | First operand |
| op_b_i | input | 16 | Second operand |
| busy_o | output | 1 | High while an operation is in progress |
| done_o | output | 1 | One-cycle pulse when result_o has been updated |
| result_o | output | 32 | Product register |

## Verification
The completion of one operation and the acceptance of the next can fall in the same cycle. In the cycle where done_o pulses, busy_o is already low, so a start request made there must begin a new computation. That request must not disturb the product just delivered. The bench provokes this by issuing every operation back to back: each new start_i is raised in the sampling slot where the previous done_o is observed. It then judges two things. First, the earlier product is still on result_o through all busy cycles of the new operation. Second, the new product arrives on result_o after the expected number of cycles. Starts made mid-operation with scrambled operands and mode additionally confirm that only the idle-time request is honoured.

// File: rtl/mul16_pkg.sv
package mul16_pkg;

    // Sequencer steps: four byte products, then optional sign fix-ups.
    typedef enum logic [2:0] {
        STEP_IDLE = 3'd0,
        STEP_LL   = 3'd1,
        STEP_HH   = 3'd2,
        STEP_LH   = 3'd3,
        STEP_HL   = 3'd4,
        STEP_FIXB = 3'd5,
        STEP_FIXA = 3'd6
    } step_e;

    // Mode captured when an operation is accepted.
    typedef struct packed {
        logic sgn;
        logic a_neg;
        logic b_neg;
    } mode_t;

    // Successor of a working step; IDLE means the step just run was the last.
    function automatic step_e step_after(step_e cur, mode_t m);
        step_e nxt;
        unique case (cur)
            STEP_LL:   nxt = STEP_HH;
            STEP_HH:   nxt = STEP_LH;
            STEP_LH:   nxt = STEP_HL;
            STEP_HL: begin
                if (m.sgn && m.b_neg)      nxt = STEP_FIXB;
                else if (m.sgn && m.a_neg) nxt = STEP_FIXA;
                else                       nxt = STEP_IDLE;
            end
            STEP_FIXB: nxt = (m.sgn && m.a_neg) ? STEP_FIXA : STEP_IDLE;
            default:   nxt = STEP_IDLE;
        endcase
        return nxt;
    endfunction

    function automatic logic is_cross(step_e s);
        return (s == STEP_LH) || (s == STEP_HL);
    endfunction

    function automatic logic is_fix(step_e s);
        return (s == STEP_FIXB) || (s == STEP_FIXA);
    endfunction

    // Which operand half feeds the shared multiplier: 1 = high byte.
    function automatic logic pick_hi_x(step_e s);
        return (s == STEP_HH) || (s == STEP_HL);
    endfunction

    function automatic logic pick_hi_y(step_e s);
        return (s == STEP_HH) || (s == STEP_LH);
    endfunction

endpackage

// File: rtl/mul16_byte_mult.sv
module mul16_byte_mult #(
    parameter int W = 8
) (
    input  logic [W-1:0]   x_i,
    input  logic [W-1:0]   y_i,
    output logic [2*W-1:0] p_o
);
    localparam int PW = 2 * W;

    logic [PW-1:0] x_ext;
    logic [PW-1:0] y_ext;

    assign x_ext = {{W{1'b0}}, x_i};
    assign y_ext = {{W{1'b0}}, y_i};
    assign p_o   = x_ext * y_ext;
endmodule

// File: rtl/mul16_opsel.sv
module mul16_opsel
    import mul16_pkg::*;
#(
    parameter int W = 8,
    localparam int H = 2 * W
) (
    input  step_e        step_i,
    input  logic [H-1:0] a_i,
    input  logic [H-1:0] b_i,
    output logic [W-1:0] x_o,
    output logic [W-1:0] y_o
);
    always_comb begin
        x_o = pick_hi_x(step_i) ? a_i[H-1:W] : a_i[W-1:0];
        y_o = pick_hi_y(step_i) ? b_i[H-1:W] : b_i[W-1:0];
    end
endmodule

// File: rtl/mul16_ctrl.sv
module mul16_ctrl
    import mul16_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  start_i,
    input  mode_t mode_i,
    output step_e step_o,
    output logic  busy_o,
    output logic  accept_o,
    output logic  last_o
);
    step_e step_q;
    step_e step_d;
    step_e succ;

    always_comb begin
        succ     = step_after(step_q, mode_i);
        accept_o = start_i && (step_q == STEP_IDLE);
        last_o   = (step_q != STEP_IDLE) && (succ == STEP_IDLE);
        if (step_q == STEP_IDLE) begin
            step_d = accept_o ? STEP_LL : STEP_IDLE;
        end else begin
            step_d = succ;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            step_q <= STEP_IDLE;
        end else begin
            step_q <= step_d;
        end
    end

    assign step_o = step_q;
    assign busy_o = (step_q != STEP_IDLE);
endmodule

// File: rtl/mul16_accum.sv
module mul16_accum
    import mul16_pkg::*;
#(
    parameter int W = 8,
    localparam int H = 2 * W,
    localparam int R = 4 * W
) (
    input  logic         clk,
    input  logic         rst,
    input  step_e        step_i,
    input  logic [H-1:0] a_i,
    input  logic [H-1:0] b_i,
    input  logic [H-1:0] prod_i,
    output logic [R-1:0] next_o
);
    logic [R-1:0] acc_q;
    logic [W-1:0] r0, r1, r2, r3;
    logic [W:0]   s1, s2;
    logic [W-1:0] s3;
    logic [H-1:0] sub_src;
    logic [W:0]   dl;
    logic [W-1:0] dh;

    assign {r3, r2, r1, r0} = acc_q;

    always_comb begin
        // Cross product added one byte up, carry rippling byte by byte.
        s1 = {1'b0, r1} + {1'b0, prod_i[W-1:0]};
        s2 = {1'b0, r2} + {1'b0, prod_i[H-1:W]} + {{W{1'b0}}, s1[W]};
        s3 = r3 + {{(W-1){1'b0}}, s2[W]};
        // Sign fix-up: subtract one operand from the upper half.
        sub_src = (step_i == STEP_FIXB) ? a_i : b_i;
        dl = {1'b0, r2} - {1'b0, sub_src[W-1:0]};
        dh = r3 - sub_src[H-1:W] - {{(W-1){1'b0}}, dl[W]};

        next_o = acc_q;
        if (step_i == STEP_LL) begin
            next_o = {{H{1'b0}}, prod_i};
        end else if (step_i == STEP_HH) begin
            next_o = {prod_i, acc_q[H-1:0]};
        end else if (is_cross(step_i)) begin
            next_o = {s3, s2[W-1:0], s1[W-1:0], r0};
        end else if (is_fix(step_i)) begin
            next_o = {dh, dl[W-1:0], r1, r0};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
        end else if (step_i != STEP_IDLE) begin
            acc_q <= next_o;
        end
    end
endmodule

// File: rtl/mul16_seq.sv
module mul16_seq
    import mul16_pkg::*;
#(
    parameter int BYTE_W = 8,
    localparam int OP_W  = 2 * BYTE_W,
    localparam int RES_W = 4 * BYTE_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             signed_i,
    input  logic [OP_W-1:0]  op_a_i,
    input  logic [OP_W-1:0]  op_b_i,
    output logic             busy_o,
    output logic             done_o,
    output logic [RES_W-1:0] result_o
);
    logic [OP_W-1:0]   a_q, b_q;
    mode_t             mode_q;
    step_e             step;
    logic              accept, last;
    logic [BYTE_W-1:0] mx, my;
    logic [OP_W-1:0]   prod;
    logic [RES_W-1:0]  acc_next;
    logic [RES_W-1:0]  result_q;
    logic              done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            a_q    <= '0;
            b_q    <= '0;
            mode_q <= '0;
        end else if (accept) begin
            a_q          <= op_a_i;
            b_q          <= op_b_i;
            mode_q.sgn   <= signed_i;
            mode_q.a_neg <= op_a_i[OP_W-1];
            mode_q.b_neg <= op_b_i[OP_W-1];
        end
    end

    mul16_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .start_i  (start_i),
        .mode_i   (mode_q),
        .step_o   (step),
        .busy_o   (busy_o),
        .accept_o (accept),
        .last_o   (last)
    );

    mul16_opsel #(.W(BYTE_W)) u_opsel (
        .step_i (step),
        .a_i    (a_q),
        .b_i    (b_q),
        .x_o    (mx),
        .y_o    (my)
    );

    mul16_byte_mult #(.W(BYTE_W)) u_mult (
        .x_i (mx),
        .y_i (my),
        .p_o (prod)
    );

    mul16_accum #(.W(BYTE_W)) u_accum (
        .clk    (clk),
        .rst    (rst),
        .step_i (step),
        .a_i    (a_q),
        .b_i    (b_q),
        .prod_i (prod),
        .next_o (acc_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            result_q <= '0;
            done_q   <= 1'b0;
        end else begin
            done_q <= last;
            if (last) begin
                result_q <= acc_next;
            end
        end
    end

    assign result_o = result_q;
    assign done_o   = done_q;
endmodule

// File: rtl/mul16_seq_chk.sv
module mul16_seq_chk
    import mul16_pkg::*;
#(
    parameter int RES_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             start_i,
    input logic             busy_o,
    input logic             done_o,
    input logic [RES_W-1:0] result_o,
    input step_e            step_i
);
    logic [3:0] busy_cnt;

    always_ff @(posedge clk) begin
        if (rst || !busy_o) begin
            busy_cnt <= '0;
        end else if (busy_cnt != 4'hF) begin
            busy_cnt <= busy_cnt + 4'd1;
        end
    end

    AST_BUSY_ON_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        (start_i && !busy_o) |=> busy_o); // R2

    AST_IDLE_STEP: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> (step_i == STEP_IDLE)); // R2

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o); // R7

    AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (!busy_o && $past(busy_o))); // R7

    AST_FALL_GIVES_DONE: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_o) |-> done_o); // R7

    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !done_o |-> $stable(result_o)); // R9

    AST_BUSY_MAX: assert property (@(posedge clk) disable iff (rst)
        busy_o |-> (busy_cnt <= 4'd5)); // R6

    AST_BUSY_MIN: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_o) |-> (busy_cnt >= 4'd4)); // R4
endmodule

bind mul16_seq mul16_seq_chk #(.RES_W(RES_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .start_i  (start_i),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .result_o (result_o),
    .step_i   (step)
);

// File: tb/tb_mul16_seq.sv
`timescale 1ns/1ps
module tb_mul16_seq;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic        signed_i = 1'b0;
    logic [15:0] op_a_i = '0;
    logic [15:0] op_b_i = '0;
    logic        busy_o, done_o;
    logic [31:0] result_o;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;  // 125 MHz

    mul16_seq dut (
        .clk(clk), .rst(rst), .start_i(start_i), .signed_i(signed_i),
        .op_a_i(op_a_i), .op_b_i(op_b_i),
        .busy_o(busy_o), .done_o(done_o), .result_o(result_o)
    );

    function automatic logic [31:0] ref_mul(input logic [15:0] a, input logic [15:0] b, input logic sgn);
        logic [31:0] ea, eb;
        ea = sgn ? {{16{a[15]}}, a} : {16'h0, a};
        eb = sgn ? {{16{b[15]}}, b} : {16'h0, b};
        return ea * eb;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Drives start in the current low phase; returns at the negedge where done is due.
    task automatic run_op(input logic [15:0] a, input logic [15:0] b, input logic sgn, input bit poke);
        logic [31:0] exp_r, prev;
        int cyc, exp_cyc;
        bit hold_ok, early_done;
        exp_r   = ref_mul(a, b, sgn);
        exp_cyc = 4 + (sgn ? (int'(a[15]) + int'(b[15])) : 0);
        prev    = result_o;
        start_i = 1'b1; op_a_i = a; op_b_i = b; signed_i = sgn;
        @(negedge clk);
        start_i = 1'b0; op_a_i = 16'($urandom); op_b_i = 16'($urandom); signed_i = ~sgn;
        check(busy_o === 1'b1, "R2 busy after accept", 32'(busy_o), 32'd1);
        cyc = 0; hold_ok = 1; early_done = 0;
        while (busy_o && cyc < 20) begin
            cyc++;
            if (result_o !== prev) hold_ok = 0;
            if (done_o) early_done = 1;
            start_i = (poke && cyc == 2);
            if (poke && cyc == 2) begin
                op_a_i = ~a; op_b_i = ~b;
            end
            @(negedge clk);
        end
        start_i = 1'b0;
        check(cyc < 20, "R7 watchdog on busy", 32'(cyc), 32'(exp_cyc));
        check(done_o === 1'b1 && !early_done, "R7 done pulse", 32'(done_o), 32'd1);
        check(hold_ok, "R9 result held while busy", prev, prev);
        if (sgn) begin
            check(result_o === exp_r, "R5 signed product", result_o, exp_r);
            check(cyc == exp_cyc, "R6 signed length", 32'(cyc), 32'(exp_cyc));
        end else begin
            check(result_o === exp_r, "R3 unsigned product", result_o, exp_r);
            check(cyc == exp_cyc, "R4 unsigned length", 32'(cyc), 32'(exp_cyc));
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [15:0] corner [5];
        logic [31:0] keep;
        corner[0] = 16'h0000; corner[1] = 16'hFFFF; corner[2] = 16'h8000;
        corner[3] = 16'h7FFF; corner[4] = 16'h0001;
        void'($urandom(32'd2718));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(busy_o === 1'b0, "R1 busy reset", 32'(busy_o), 32'd0);
        check(done_o === 1'b0, "R1 done reset", 32'(done_o), 32'd0);
        check(result_o === 32'd0, "R1 result reset", result_o, 32'd0);

        // Directed corners in both modes; each run starts in the prior done cycle (R10).
        for (int m = 0; m < 2; m++)
            for (int i = 0; i < 5; i++)
                for (int j = 0; j < 5; j++)
                    run_op(corner[i], corner[j], m[0], 1'b0);

        // Starts during busy must be ignored (R8).
        for (int k = 0; k < 6; k++) begin
            run_op(16'($urandom), 16'h8000 | 16'($urandom), k[0], 1'b1);
            keep = result_o;
            @(negedge clk);
            check(busy_o === 1'b0, "R8 no extra operation", 32'(busy_o), 32'd0);
            check(done_o === 1'b0 && result_o === keep, "R8 no extra done", result_o, keep);
        end

        // Back-to-back chain from the done cycle (R10).
        run_op(16'h1234, 16'h5678, 1'b0, 1'b0);
        check(done_o === 1'b1, "R10 start in done cycle", 32'(done_o), 32'd1);
        run_op(16'hFEDC, 16'h0003, 1'b1, 1'b0);

        // Constrained random.
        for (int k = 0; k < 300; k++)
            run_op(16'($urandom), 16'($urandom), 1'($urandom), (k % 7) == 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule